// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This block moves outgoing frames from memory to a streaming sink by following a linked list of descriptors. Software builds the list, writes the list head into the base register, sets the MAC transmit enable in the first configuration register and then writes 1 to the control register. The engine fetches each descriptor over a simple word port. A descriptor is three 32-bit words: the buffer pointer at offset 0, the size word at offset 4 and the next pointer at offset 8. In the size word, bit 31 set means the descriptor holds no frame, and bits [10:0] give the byte count. For each full descriptor the engine streams the payload as 32-bit little-endian beats, marks the descriptor empty, counts the frame and moves on to the next one. When it meets an empty descriptor it flags underrun and drops its own enable.

Frames go to the transmit stream, or to a loopback stream toward the local receiver when loopback is configured. The two streams share one set of data signals. A masked interrupt merges four transmit status bits with four receive status bits that come in from the receive side. Writing configuration bit 31 restores every register to its reset value.

Register word indices: 0 config-1 (bit 0 transmit enable, bit 8 loopback, bit 31 soft reset), 1 config-2, 2 gap timing, 3 half-duplex, 4 max-frame, 5 FIFO config, 6 control (bit 0 enable), 7 descriptor base, 8 status, 9 interrupt mask, 10 interrupt status (read only).

Top module: `txd_chain_dma`

## Requirements
- R1: After reset, config-1 reads 0x80000000, config-2 reads 0x7000, gap timing reads 0x40605060, half-duplex reads 0x00A1F037, max-frame reads 0x600 and FIFO config reads 0x3FFFF. Control, base, status and mask read 0, and irq is low.
- R2: A write to config-1 with bit 31 set restores every register to its R1 value, status included.
- R3: Writing control bit 0 = 1 while config-1 bit 0 is clear makes no memory access. The control bit still reads back as 1.
- R4: For a full descriptor, the engine reads the buffer pointer (offset 0), the size word (offset 4) and the next pointer (offset 8). It then streams ceil(n/4) beats from consecutive buffer words, where n is size bits [10:0]. tx_last marks the final beat, and tx_keep on that beat is 0x1/0x3/0x7/0xF for n mod 4 = 1/2/3/0. Every other beat has tx_keep 0xF.
- R5: A beat stays valid with stable data until it is accepted. The next descriptor is not read until the frame's last beat has been accepted.
- R6: After a frame, the size word with bit 31 set is written back to descriptor offset 4.
- R7: Each sent frame adds 1 to status bits [23:16] and sets status bit 0.
- R8: On reaching a descriptor whose size bit 31 is set, the engine sets status bit 1 (underrun) and clears control bit 0.
- R9: With config-1 bit 8 set, beats appear on the loopback valid and none on tx_valid. The two valids are never high together.
- R10: The base register ignores address bits [1:0].
- R11: Writing 1 to status bit 1 clears underrun. Writing 1 to status bit 0 decrements the count, and clears bit 0 only when the count reaches zero.
- R12: Interrupt status equals mask[7:0] AND {rx_stat[3:0], status[3:0]}. irq goes high one cycle after that value becomes non-zero.
- R13: A descriptor with byte count 0 streams no beat but is still written back and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, registered one cycle after reg_rd |
| rx_stat | input | 4 | Receive-side status bits for the interrupt |
| irq | output | 1 | Registered interrupt line |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 32 | Beat data for both streams |
| tx_keep | output | 4 | Byte enables of the beat |
| tx_last | output | 1 | Last beat of a frame |
| tx_valid | output | 1 | Beat valid toward transmit |
| tx_ready | input | 1 | Transmit sink ready |
| lb_valid | output | 1 | Beat valid toward loopback |
| lb_ready | input | 1 | Loopback sink ready |

## Verification
A register read returns data one cycle after the strobe, so the bench samples reg_rdata at the falling edge that ends the read. A register write takes effect at the next rising edge, and irq follows the interrupt status one cycle later. Frame results (count, write-back, underrun) depend on memory latency and sink back-pressure. For these the bench polls the control bit until the engine clears it and only then checks memory, status and the captured beats. It tags the cycles of the last accepted beat and of the next descriptor fetch to confirm their order.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W = 32;
  localparam int RA_W   = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_SIZE, S_NEXT, S_FETCH, S_PUSH, S_WBACK, S_END
  } wstate_t;

  localparam logic [RA_W-1:0] A_CFG1  = 4'd0;
  localparam logic [RA_W-1:0] A_CFG2  = 4'd1;
  localparam logic [RA_W-1:0] A_GAP   = 4'd2;
  localparam logic [RA_W-1:0] A_HDX   = 4'd3;
  localparam logic [RA_W-1:0] A_MAXF  = 4'd4;
  localparam logic [RA_W-1:0] A_FIFO  = 4'd5;
  localparam logic [RA_W-1:0] A_CTL   = 4'd6;
  localparam logic [RA_W-1:0] A_BASE  = 4'd7;
  localparam logic [RA_W-1:0] A_STAT  = 4'd8;
  localparam logic [RA_W-1:0] A_MASK  = 4'd9;
  localparam logic [RA_W-1:0] A_ISR   = 4'd10;

  localparam logic [WORD_W-1:0] D_CFG1 = 32'h8000_0000;
  localparam logic [WORD_W-1:0] D_CFG2 = 32'h0000_7000;
  localparam logic [WORD_W-1:0] D_GAP  = 32'h4060_5060;
  localparam logic [WORD_W-1:0] D_HDX  = 32'h00A1_F037;
  localparam logic [WORD_W-1:0] D_MAXF = 32'h0000_0600;
  localparam logic [WORD_W-1:0] D_FIFO = 32'h0003_FFFF;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [3:0]        rx_stat,
  input  logic              sent_pulse,
  input  logic              done_pulse,
  output logic              start,
  output logic              soft_rst,
  output logic              tx_en,
  output logic              lb_mode,
  output logic [AW-1:2]     base_w,
  output logic              irq
);
  localparam int PAD_W = WORD_W - 16 - CNT_W;

  logic [WORD_W-1:0] cfg1, cfg2, gap, hdx, maxf, fifo, mask;
  logic              ctl_en, underrun, sent_flag;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [WORD_W-1:0] stat_w, isr_w, base_rd;
  logic              wr_stat, dec, clr_un;

  assign soft_rst = reg_wr && reg_addr == A_CFG1 && reg_wdata[31];
  assign wr_stat  = reg_wr && reg_addr == A_STAT;
  assign dec      = wr_stat && reg_wdata[0];
  assign clr_un   = wr_stat && reg_wdata[1];
  assign start    = reg_wr && reg_addr == A_CTL && reg_wdata[0] && cfg1[0];
  assign tx_en    = cfg1[0];
  assign lb_mode  = cfg1[8];
  assign cnt_nx   = cnt + CNT_W'(sent_pulse) - CNT_W'(dec);
  assign stat_w   = {{PAD_W{1'b0}}, cnt, 14'd0, underrun, sent_flag};
  assign isr_w    = mask & {24'd0, rx_stat, stat_w[3:0]};
  assign base_rd  = WORD_W'({base_w, 2'b00});

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg1 <= D_CFG1; cfg2 <= D_CFG2; gap <= D_GAP; hdx <= D_HDX;
      maxf <= D_MAXF; fifo <= D_FIFO; mask <= '0;
      ctl_en <= 1'b0; base_w <= '0;
      cnt <= '0; underrun <= 1'b0; sent_flag <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= |isr_w;
      cnt <= cnt_nx;
      if (sent_pulse)            sent_flag <= 1'b1;
      else if (dec && cnt_nx == '0) sent_flag <= 1'b0;
      if (done_pulse)            underrun <= 1'b1;
      else if (clr_un)           underrun <= 1'b0;
      if (done_pulse)            ctl_en <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          A_CFG1: cfg1   <= reg_wdata;
          A_CFG2: cfg2   <= reg_wdata;
          A_GAP:  gap    <= reg_wdata;
          A_HDX:  hdx    <= reg_wdata;
          A_MAXF: maxf   <= reg_wdata;
          A_FIFO: fifo   <= reg_wdata;
          A_CTL:  ctl_en <= reg_wdata[0];
          A_BASE: base_w <= reg_wdata[AW-1:2];
          A_MASK: mask   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_CFG1: reg_rdata <= cfg1;
        A_CFG2: reg_rdata <= cfg2;
        A_GAP:  reg_rdata <= gap;
        A_HDX:  reg_rdata <= hdx;
        A_MAXF: reg_rdata <= maxf;
        A_FIFO: reg_rdata <= fifo;
        A_CTL:  reg_rdata <= {31'd0, ctl_en};
        A_BASE: reg_rdata <= base_rd;
        A_STAT: reg_rdata <= stat_w;
        A_MASK: reg_rdata <= mask;
        A_ISR:  reg_rdata <= isr_w;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R7
  cnt_inc_chk: assert property (@(posedge clk) disable iff (rst)
    sent_pulse && !dec && !soft_rst |=> cnt == $past(cnt) + 1'b1 && sent_flag);

  // R8
  underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse && !soft_rst |=> underrun);

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_un && !done_pulse && !soft_rst |=> !underrun);
endmodule

// File: rtl/txd_walker.sv
module txd_walker
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tx_en,
  input  logic              lb_mode,
  input  logic [AW-1:2]     base_w,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] out_data,
  output logic [3:0]        out_keep,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              route_lb,
  output logic              sent_pulse,
  output logic              done_pulse
);
  localparam int BW = LEN_W - 1;

  wstate_t           st;
  logic [AW-1:0]     cur, nxt, buf_ptr;
  logic [WORD_W-1:0] sz_word;
  logic [BW-1:0]     beats_left;
  logic [LEN_W-1:0]  len;
  logic [LEN_W:0]    len_up;
  logic [3:0]        tail_keep;

  assign len    = sz_word[LEN_W-1:0];
  assign len_up = {1'b0, len} + (LEN_W+1)'(3);

  always_comb begin
    for (int b = 0; b < 4; b++)
      tail_keep[b] = (len[1:0] == 2'd0) || (b < int'(len[1:0]));
  end

  always_comb begin
    mem_req   = st inside {S_ADDR, S_SIZE, S_NEXT, S_FETCH, S_WBACK};
    mem_we    = st == S_WBACK;
    mem_wdata = sz_word | 32'h8000_0000;
    case (st)
      S_SIZE, S_WBACK: mem_addr = cur + AW'(4);
      S_NEXT:          mem_addr = cur + AW'(8);
      S_FETCH:         mem_addr = buf_ptr;
      default:         mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cur <= '0; nxt <= '0; buf_ptr <= '0; sz_word <= '0;
      beats_left <= '0; out_data <= '0; out_keep <= '0; out_last <= 1'b0;
      out_valid <= 1'b0; route_lb <= 1'b0;
      sent_pulse <= 1'b0; done_pulse <= 1'b0;
    end else begin
      sent_pulse <= 1'b0;
      done_pulse <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cur <= {base_w, 2'b00};
          st  <= S_ADDR;
        end
        S_ADDR: if (mem_ack) begin
          buf_ptr <= mem_rdata[AW-1:0];
          st      <= S_SIZE;
        end
        S_SIZE: if (mem_ack) begin
          sz_word <= mem_rdata;
          st      <= mem_rdata[31] ? S_END : S_NEXT;
        end
        S_NEXT: if (mem_ack) begin
          nxt        <= mem_rdata[AW-1:0];
          route_lb   <= lb_mode;
          beats_left <= len_up[LEN_W:2];
          st         <= (len == '0) ? S_WBACK : S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          out_data   <= mem_rdata;
          out_valid  <= 1'b1;
          out_last   <= beats_left == BW'(1);
          out_keep   <= (beats_left == BW'(1)) ? tail_keep : 4'hF;
          buf_ptr    <= buf_ptr + AW'(4);
          beats_left <= beats_left - 1'b1;
          st         <= S_PUSH;
        end
        S_PUSH: if (out_ready) begin
          out_valid <= 1'b0;
          st        <= out_last ? S_WBACK : S_FETCH;
        end
        S_WBACK: if (mem_ack) begin
          sent_pulse <= 1'b1;
          cur        <= nxt;
          st         <= tx_en ? S_ADDR : S_IDLE;
        end
        S_END: begin
          done_pulse <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R5
  no_fetch_during_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !mem_req);

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11,
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  rx_stat,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [31:0] tx_data,
  output logic [3:0]  tx_keep,
  output logic        tx_last,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        lb_valid,
  input  logic        lb_ready
);
  logic          start, soft_rst, tx_en, lb_mode, route_lb, out_valid;
  logic          sent_pulse, done_pulse;
  logic [AW-1:2] base_w;

  txd_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_stat(rx_stat), .sent_pulse(sent_pulse), .done_pulse(done_pulse),
    .start(start), .soft_rst(soft_rst), .tx_en(tx_en), .lb_mode(lb_mode),
    .base_w(base_w), .irq(irq)
  );

  txd_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst || soft_rst), .start(start), .tx_en(tx_en),
    .lb_mode(lb_mode), .base_w(base_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_data(tx_data), .out_keep(tx_keep), .out_last(tx_last),
    .out_valid(out_valid), .out_ready(route_lb ? lb_ready : tx_ready),
    .route_lb(route_lb), .sent_pulse(sent_pulse), .done_pulse(done_pulse)
  );

  assign tx_valid = out_valid && !route_lb;
  assign lb_valid = out_valid && route_lb;

  // R9
  one_path_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_valid, lb_valid}));
endmodule

// File: tb/txd_chain_dma_tb.sv
`timescale 1ns/1ps
module txd_chain_dma_tb;
  logic        clk = 1'b0;
  logic        rst, reg_wr, reg_rd;
  logic [3:0]  reg_addr, rx_stat;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, tx_data;
  logic [31:0] mem_rdata;
  logic        irq, mem_req, mem_we, mem_ack, tx_last, tx_valid, lb_valid;
  logic        tx_ready, lb_ready, throttle;
  logic [3:0]  tx_keep;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int memreq_n = 0, tx_n = 0, lb_n = 0;
  int last_cyc = 0, track_cyc = 0;
  logic [31:0] track_addr = 32'hFFFF_FFFF;
  logic [31:0] cap_d [0:31];
  logic [3:0]  cap_k [0:31];
  logic        cap_l [0:31];
  logic [31:0] mem [0:255];

  always #2.5 clk = ~clk;

  txd_chain_dma u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_stat(rx_stat), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_keep(tx_keep),
    .tx_last(tx_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .lb_valid(lb_valid), .lb_ready(lb_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack  <= 1'b1;
        memreq_n <= memreq_n + 1;
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[9:2]];
        if (!mem_we && mem_addr == track_addr && track_cyc == 0) track_cyc <= cyc;
      end
    end
    if (tx_valid && tx_ready) begin
      cap_d[tx_n % 32] <= tx_data; cap_k[tx_n % 32] <= tx_keep;
      cap_l[tx_n % 32] <= tx_last; tx_n <= tx_n + 1;
      if (tx_last && last_cyc == 0) last_cyc <= cyc;
    end
    if (lb_valid && lb_ready) lb_n <= lb_n + 1;
  end

  always @(negedge clk) begin
    tx_ready <= throttle ? (cyc % 3 != 0) : 1'b1;
    lb_ready <= throttle ? (cyc % 4 != 1) : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd_reg(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(4'd6, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic check_defaults(input string tag);
    expect_reg(4'd0, 32'h8000_0000, tag);
    expect_reg(4'd1, 32'h0000_7000, tag);
    expect_reg(4'd2, 32'h4060_5060, tag);
    expect_reg(4'd3, 32'h00A1_F037, tag);
    expect_reg(4'd4, 32'h0000_0600, tag);
    expect_reg(4'd5, 32'h0003_FFFF, tag);
    expect_reg(4'd6, 32'h0, tag);
    expect_reg(4'd8, 32'h0, tag);
    expect_reg(4'd9, 32'h0, tag);
  endtask

  task automatic t_reset();
    check_defaults("R1");
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    chk(tx_valid == 1'b0, "R1 tx_valid", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_no_enable();
    int n0;
    wr_reg(4'd0, 32'h0);
    n0 = memreq_n;
    wr_reg(4'd6, 32'h1);
    repeat (20) @(negedge clk);
    chk(memreq_n == n0, "R3 mem access", memreq_n, n0);
    expect_reg(4'd6, 32'h1, "R3 ctl readback");
    wr_reg(4'd6, 32'h0);
  endtask

  task automatic t_chain();
    int n0;
    mem[16] = 32'h100; mem[17] = 32'd6;  mem[18] = 32'h50;
    mem[20] = 32'h120; mem[21] = 32'd4;  mem[22] = 32'h60;
    mem[24] = 32'h0;   mem[25] = 32'h8000_0000; mem[26] = 32'h0;
    mem[64] = 32'h1122_3344; mem[65] = 32'h0000_5566;
    mem[72] = 32'hAABB_CCDD;
    throttle = 1'b1; track_addr = 32'h50; track_cyc = 0; last_cyc = 0;
    n0 = tx_n;
    wr_reg(4'd0, 32'h1);
    wr_reg(4'd7, 32'h43);
    expect_reg(4'd7, 32'h40, "R10 base alignment");
    wr_reg(4'd6, 32'h1);
    wait_done();
    throttle = 1'b0;
    chk(tx_n - n0 == 3, "R4 beat count", tx_n - n0, 3);
    chk(cap_d[n0%32] == 32'h1122_3344 && cap_k[n0%32] == 4'hF && !cap_l[n0%32],
        "R4 beat0", cap_d[n0%32], 32'h1122_3344);
    chk(cap_d[(n0+1)%32] == 32'h5566 && cap_k[(n0+1)%32] == 4'h3 && cap_l[(n0+1)%32],
        "R4 tail keep", {24'd0, cap_k[(n0+1)%32], 3'd0, cap_l[(n0+1)%32]}, 32'h31);
    chk(cap_d[(n0+2)%32] == 32'hAABB_CCDD && cap_k[(n0+2)%32] == 4'hF && cap_l[(n0+2)%32],
        "R4 frame1", cap_d[(n0+2)%32], 32'hAABB_CCDD);
    chk(track_cyc > last_cyc && last_cyc != 0, "R5 fetch after last", track_cyc, last_cyc);
    chk(mem[17] == 32'h8000_0006, "R6 writeback d0", mem[17], 32'h8000_0006);
    chk(mem[21] == 32'h8000_0004, "R6 writeback d1", mem[21], 32'h8000_0004);
    expect_reg(4'd8, 32'h0002_0003, "R7 R8 status");
    expect_reg(4'd6, 32'h0, "R8 enable cleared");
  endtask

  task automatic t_ack();
    wr_reg(4'd8, 32'h1);
    expect_reg(4'd8, 32'h0001_0003, "R11 dec keeps bit0");
    wr_reg(4'd8, 32'h2);
    expect_reg(4'd8, 32'h0001_0001, "R11 underrun clear");
    wr_reg(4'd8, 32'h1);
    expect_reg(4'd8, 32'h0, "R11 count zero");
  endtask

  task automatic t_loop();
    int t0, l0;
    mem[32] = 32'h140; mem[33] = 32'd8; mem[34] = 32'h90;
    mem[36] = 32'h0;   mem[37] = 32'd0; mem[38] = 32'hA0;
    mem[40] = 32'h0;   mem[41] = 32'h8000_0000; mem[42] = 32'h0;
    mem[80] = 32'h0102_0304; mem[81] = 32'h0506_0708;
    throttle = 1'b1;
    t0 = tx_n; l0 = lb_n;
    wr_reg(4'd0, 32'h101);
    wr_reg(4'd7, 32'h80);
    wr_reg(4'd6, 32'h1);
    wait_done();
    throttle = 1'b0;
    chk(lb_n - l0 == 2, "R9 loopback beats", lb_n - l0, 2);
    chk(tx_n == t0, "R9 no tx beats", tx_n - t0, 0);
    chk(mem[37] == 32'h8000_0000, "R13 zero length writeback", mem[37], 32'h8000_0000);
    expect_reg(4'd8, 32'h0002_0003, "R13 zero length counted");
  endtask

  task automatic t_irq();
    wr_reg(4'd9, 32'h02);
    expect_reg(4'd10, 32'h02, "R12 tx underrun isr");
    chk(irq == 1'b1, "R12 irq high", {31'd0, irq}, 32'd1);
    rx_stat = 4'h1;
    wr_reg(4'd9, 32'h10);
    expect_reg(4'd10, 32'h10, "R12 rx isr");
    chk(irq == 1'b1, "R12 irq rx", {31'd0, irq}, 32'd1);
    rx_stat = 4'h0;
    @(negedge clk); @(negedge clk);
    chk(irq == 1'b0, "R12 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_soft();
    wr_reg(4'd0, 32'h8000_0000);
    check_defaults("R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 4'd0;
    reg_wdata = 32'h0; rx_stat = 4'h0; throttle = 1'b0;
    tx_ready = 1'b1; lb_ready = 1'b1; mem_rdata = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_no_enable();
    t_chain();
    t_ack();
    t_loop();
    t_irq();
    t_soft();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule